// File: doc/BRIEF.md
# Serial-Bus Receive Packet Filter

This block sits between the receive side of a serial-bus physical-layer interface and two receive queues. Packets arrive one 32-bit quadlet per cycle, framed by start and end markers. The first quadlet of each packet is decoded once. Its transaction code gives the packet class, isochronous or asynchronous. Its address or channel field then decides whether this node keeps the packet.

A kept packet goes to the queue that matches its class. Every quadlet of it is written, starting with the header, and each write appears one clock after the quadlet arrives. A packet that is not kept produces no writes. If the target queue reports full partway through a kept packet, the filter drops the rest of that packet and raises a one-cycle overflow pulse. The node ID, the isochronous channel and a snoop switch come from static configuration inputs.

Top module: `rx_pkt_filter`

## Requirements
- R1: A packet whose transaction code (first quadlet bits [7:4]) is not 0xA is asynchronous. It is kept when its destination ID (bits [31:16]) equals `cfg_node_id`.
- R2: A packet with transaction code 0xA is isochronous. It is kept when its channel (bits [13:8]) equals `cfg_iso_chan`. The destination field plays no part.
- R3: An asynchronous packet whose destination node field (bits [21:16]) is 63 is a broadcast. It is kept whatever the rest of its destination ID holds.
- R4: While `cfg_snoop` is high, every packet is kept without any comparison.
- R5: Kept asynchronous packets are written only to the async queue, and kept isochronous packets only to the iso queue. The two write enables are never high together.
- R6: A packet that is not kept causes no write on either queue.
- R7: Each kept quadlet, the header included, is written with its data unchanged, in order, one clock after it is presented.
- R8: The keep decision made at the start quadlet holds until the end quadlet. A valid quadlet outside a packet (no start seen) is ignored. A quadlet with both markers set is a one-quadlet packet.
- R9: If the target queue's full input is high while a kept quadlet is presented, that quadlet and the rest of the packet are dropped, even if full falls again. `overflow` pulses for one cycle, one clock after the first dropped quadlet. Full on the other queue has no effect.
- R10: After reset, both write enables and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_node_id | input | 16 | Node ID of this node (bus and node fields) |
| cfg_iso_chan | input | 6 | Isochronous channel to receive |
| cfg_snoop | input | 1 | Keep every packet |
| in_valid | input | 1 | Quadlet present |
| in_sop | input | 1 | First quadlet of a packet |
| in_eop | input | 1 | Last quadlet of a packet |
| in_data | input | 32 | Quadlet |
| async_full | input | 1 | Async queue cannot accept |
| async_wr | output | 1 | Async queue write enable |
| async_wdata | output | 32 | Async queue write data |
| iso_full | input | 1 | Iso queue cannot accept |
| iso_wr | output | 1 | Iso queue write enable |
| iso_wdata | output | 32 | Iso queue write data |
| overflow | output | 1 | Packet cut short by a full queue |

## Verification
On every cycle, the assertions check the following. The two queues are never written together. Every write has a valid quadlet one cycle earlier and carries that quadlet's data. No write follows a cycle in which that queue was full. An overflow pulse always follows a valid quadlet and a full queue. The acceptance rules are shown only by the bench's sweeps: node, channel, broadcast and snoop, each tried against every transaction code. The same holds for the drop of a whole packet after a single cycle of full, for stray quadlets, and for one-quadlet packets.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [3:0] TCODE_ISO = 4'hA;
  localparam int Q_ASYNC = 0;
  localparam int Q_ISO   = 1;
  localparam int NUM_Q   = 2;

  function automatic logic [3:0] hdr_tcode(input logic [31:0] h);
    return h[7:4];
  endfunction

  function automatic logic hdr_is_iso(input logic [31:0] h);
    return hdr_tcode(h) == TCODE_ISO;
  endfunction

  function automatic logic [5:0] hdr_chan(input logic [31:0] h);
    return h[13:8];
  endfunction

  function automatic logic [15:0] hdr_dest(input logic [31:0] h);
    return h[31:16];
  endfunction

  function automatic logic dest_is_bcast(input logic [15:0] d);
    return d[5:0] == 6'h3F;
  endfunction
endpackage

// File: rtl/rxf_hdr_match.sv
module rxf_hdr_match
  import rxf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] hdr,
  input  logic [15:0]       cfg_node_id,
  input  logic [5:0]        cfg_iso_chan,
  input  logic              cfg_snoop,
  output logic              keep,
  output logic              to_iso
);
  logic [31:0] h32;
  logic        iso_hit;
  logic        async_hit;

  assign h32       = hdr[31:0];
  assign to_iso    = hdr_is_iso(h32);
  assign iso_hit   = hdr_chan(h32) == cfg_iso_chan;
  assign async_hit = (hdr_dest(h32) == cfg_node_id) || dest_is_bcast(hdr_dest(h32));
  assign keep      = cfg_snoop || (to_iso ? iso_hit : async_hit);
endmodule

// File: rtl/rxf_pkt_track.sv
module rxf_pkt_track
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             keep_now,
  input  logic             iso_now,
  input  logic [NUM_Q-1:0] q_full,
  output logic [NUM_Q-1:0] pass,
  output logic             ovf_evt
);
  logic in_pkt_q, keep_q, iso_q, drop_q;
  logic start, active, sel_iso, dropping, sel_full;

  assign start    = in_valid && in_sop;
  assign active   = start ? keep_now : (in_pkt_q && keep_q);
  assign sel_iso  = start ? iso_now : iso_q;
  assign dropping = start ? 1'b0 : drop_q;
  assign sel_full = sel_iso ? q_full[Q_ISO] : q_full[Q_ASYNC];
  assign ovf_evt  = in_valid && active && !dropping && sel_full;

  always_comb begin
    pass = '0;
    if (in_valid && active && !dropping && !sel_full) begin
      if (sel_iso) pass[Q_ISO] = 1'b1;
      else         pass[Q_ASYNC] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      keep_q   <= 1'b0;
      iso_q    <= 1'b0;
      drop_q   <= 1'b0;
    end else if (in_valid) begin
      in_pkt_q <= (start || in_pkt_q) && !in_eop;
      keep_q   <= active;
      iso_q    <= sel_iso;
      drop_q   <= dropping || ovf_evt;
    end
  end
endmodule

// File: rtl/rxf_q_write.sv
module rxf_q_write #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass,
  input  logic [DATA_W-1:0] din,
  output logic              wr,
  output logic [DATA_W-1:0] wdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr    <= 1'b0;
      wdata <= '0;
    end else begin
      wr <= pass;
      if (pass) wdata <= din;
    end
  end
endmodule

// File: rtl/rx_pkt_filter.sv
module rx_pkt_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cfg_node_id,
  input  logic [5:0]        cfg_iso_chan,
  input  logic              cfg_snoop,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  input  logic              async_full,
  output logic              async_wr,
  output logic [DATA_W-1:0] async_wdata,
  input  logic              iso_full,
  output logic              iso_wr,
  output logic [DATA_W-1:0] iso_wdata,
  output logic              overflow
);
  logic              keep_now, iso_now, ovf_evt;
  logic [NUM_Q-1:0]  q_full, pass, q_wr;
  logic [DATA_W-1:0] q_wdata [NUM_Q];

  assign q_full[Q_ASYNC] = async_full;
  assign q_full[Q_ISO]   = iso_full;

  rxf_hdr_match #(.DATA_W(DATA_W)) u_match (
    .hdr(in_data), .cfg_node_id(cfg_node_id), .cfg_iso_chan(cfg_iso_chan),
    .cfg_snoop(cfg_snoop), .keep(keep_now), .to_iso(iso_now)
  );

  rxf_pkt_track u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .keep_now(keep_now), .iso_now(iso_now),
    .q_full(q_full), .pass(pass), .ovf_evt(ovf_evt)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    rxf_q_write #(.DATA_W(DATA_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .pass(pass[q]), .din(in_data),
      .wr(q_wr[q]), .wdata(q_wdata[q])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= ovf_evt;
  end

  assign async_wr    = q_wr[Q_ASYNC];
  assign async_wdata = q_wdata[Q_ASYNC];
  assign iso_wr      = q_wr[Q_ISO];
  assign iso_wdata   = q_wdata[Q_ISO];
endmodule

// File: rtl/rx_pkt_filter_chk.sv
module rx_pkt_filter_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              async_full,
  input logic              iso_full,
  input logic              async_wr,
  input logic [DATA_W-1:0] async_wdata,
  input logic              iso_wr,
  input logic [DATA_W-1:0] iso_wdata,
  input logic              overflow
);
  a_r5_one_queue: assert property (@(posedge clk) disable iff (!rst_n)
    !(async_wr && iso_wr));
  a_r7_write_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    (async_wr || iso_wr) |-> $past(in_valid));
  a_r7_async_data: assert property (@(posedge clk) disable iff (!rst_n)
    async_wr |-> async_wdata == $past(in_data));
  a_r7_iso_data: assert property (@(posedge clk) disable iff (!rst_n)
    iso_wr |-> iso_wdata == $past(in_data));
  a_r9_no_async_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    async_wr |-> !$past(async_full));
  a_r9_no_iso_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    iso_wr |-> !$past(iso_full));
  a_r9_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(in_valid) && ($past(async_full) || $past(iso_full)));
  a_r9_overflow_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !(async_wr || iso_wr));
endmodule

bind rx_pkt_filter rx_pkt_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .async_full(async_full), .iso_full(iso_full), .async_wr(async_wr),
  .async_wdata(async_wdata), .iso_wr(iso_wr), .iso_wdata(iso_wdata),
  .overflow(overflow)
);

// File: tb/rx_pkt_filter_test.sv
`timescale 1ns/1ps
module rx_pkt_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_node_id = 16'hFFC2;
  logic [5:0]  cfg_iso_chan = 6'd5;
  logic        cfg_snoop = 1'b0;
  logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        async_full = 1'b0, iso_full = 1'b0;
  logic        async_wr, iso_wr, overflow;
  logic [31:0] async_wdata, iso_wdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_pkt_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_node_id(cfg_node_id), .cfg_iso_chan(cfg_iso_chan),
    .cfg_snoop(cfg_snoop), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .async_full(async_full), .async_wr(async_wr),
    .async_wdata(async_wdata), .iso_full(iso_full), .iso_wr(iso_wr),
    .iso_wdata(iso_wdata), .overflow(overflow)
  );

  // One quadlet in, outputs compared one clock later.
  task automatic step(input logic v, input logic s, input logic e, input logic [31:0] d,
                      input logic fa, input logic fi, input logic ea, input logic ei,
                      input logic eo, input string req);
    @(negedge clk);
    in_valid = v; in_sop = s; in_eop = e; in_data = d; async_full = fa; iso_full = fi;
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; async_full = 1'b0; iso_full = 1'b0;
    checks++;
    if (async_wr !== ea || iso_wr !== ei || overflow !== eo ||
        (ea && async_wdata !== d) || (ei && iso_wdata !== d)) begin
      errors++;
      $display("FAIL %s: wr a/i/ovf=%b%b%b data a=%h i=%h, expected %b%b%b data=%h",
               req, async_wr, iso_wr, overflow, async_wdata, iso_wdata, ea, ei, eo, d);
    end
  endtask

  // Packet of len quadlets; full pulses on queue fq (0 async, 1 iso) at index fat.
  task automatic send_pkt(input logic [31:0] hdr, input int len, input int fq,
                          input int fat, input string req);
    logic iso, keep, drop;
    iso  = hdr[7:4] == 4'hA;
    keep = cfg_snoop || (iso ? hdr[13:8] == cfg_iso_chan
                             : (hdr[31:16] == cfg_node_id || hdr[21:16] == 6'h3F));
    drop = 1'b0;
    for (int i = 0; i < len; i++) begin
      logic fa, fi, hit, wa, wi, ov;
      logic [31:0] d;
      d   = (i == 0) ? hdr : (32'hC0DE_0000 ^ (hdr << 3) ^ 32'(i));
      fa  = (fq == 0) && (i == fat);
      fi  = (fq == 1) && (i == fat);
      hit = keep && !drop && (iso ? fi : fa);
      ov  = hit;
      wa  = keep && !drop && !hit && !iso;
      wi  = keep && !drop && !hit && iso;
      if (hit) drop = 1'b1;
      step(1'b1, i == 0, i == len - 1, d, fa, fi, wa, wi, ov, req);
    end
    step(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6 idle");
  endtask

  function automatic logic [31:0] mk_hdr(input logic [3:0] tc, input int variant);
    logic [15:0] dest;
    logic [5:0]  ch;
    if (tc == 4'hA) begin
      ch = (variant == 0) ? cfg_iso_chan : (variant == 1) ? cfg_iso_chan ^ 6'd1 : 6'd63;
      dest = cfg_node_id;  // irrelevant to isochronous matching (R2)
      return {dest ^ 16'h0100, 2'b00, ch, tc, 4'h3};
    end
    dest = (variant == 0) ? cfg_node_id : (variant == 1) ? cfg_node_id ^ 16'h0001
                                                         : {cfg_node_id[15:6] ^ 10'h2A5, 6'h3F};
    return {dest, 2'b00, cfg_iso_chan, tc, 4'h1};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (async_wr !== 1'b0 || iso_wr !== 1'b0 || overflow !== 1'b0) begin
      errors++;
      $display("FAIL R10: reset outputs %b%b%b, expected 000", async_wr, iso_wr, overflow);
    end
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6 R7: every transaction code, match / mismatch / broadcast, snoop off and on
    for (int sn = 0; sn < 2; sn++) begin
      cfg_snoop = sn[0];
      for (int tc = 0; tc < 16; tc++)
        for (int v = 0; v < 3; v++)
          send_pkt(mk_hdr(4'(tc), v), 3, 2, 99, "R1 R2 R3 R4 R5 R6 R7 sweep");
    end
    cfg_snoop = 1'b0;

    // R8: one-quadlet packets and stray quadlets outside a packet
    send_pkt(mk_hdr(4'h1, 0), 1, 2, 99, "R8 single async");
    send_pkt(mk_hdr(4'hA, 0), 1, 2, 99, "R8 single iso");
    step(1'b1, 1'b0, 1'b0, mk_hdr(4'h1, 0), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 stray quadlet");
    step(1'b1, 1'b0, 1'b1, mk_hdr(4'hA, 0), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 stray end");
    // R8: rejected packet stays rejected for its whole body
    send_pkt(mk_hdr(4'h1, 1), 5, 2, 99, "R8 R6 long rejected");

    // R9: full at each position on the target queue, then on the other queue
    for (int p = 0; p < 4; p++) begin
      send_pkt(mk_hdr(4'h1, 0), 4, 0, p, "R9 async full");
      send_pkt(mk_hdr(4'hA, 0), 4, 1, p, "R9 iso full");
      send_pkt(mk_hdr(4'h1, 2), 4, 1, p, "R9 other queue full");
      send_pkt(mk_hdr(4'hA, 0), 4, 0, p, "R9 other queue full");
    end
    // R9: a new packet after an overflow is received normally
    send_pkt(mk_hdr(4'h4, 0), 3, 2, 99, "R9 recovery");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule